// File: doc/BRIEF.md
# Block Security Table Register Bank

This register bank holds the configuration of a block-granular memory security filter. Memory is split into equal blocks. Each block has one bit in a table of 32-bit words: 0 marks the block secure and 1 marks it non-secure. Software reaches the table through an index register and a single data window. The index can step forward by itself after every full-word access, so software can stream the whole table in one burst.

The bank also holds the interrupt controls for the filter's violation reports. The violation capture logic sits outside the bank. It raises a pulse and supplies two information words, and the bank passes both words to software unchanged. A lockdown bit freezes the control word, the table and the interrupt enable, and only reset clears it.

Non-secure masters can see only the identification words at the top of the map. The filter data path reads the table through a combinational lookup port and reads the error-response select bit from a dedicated output.

Top module: `sec_lut_regs`

## Requirements
- R1: Reset state. After reset the control word reads 0x00000100, which means auto-step is on. The index, interrupt status and interrupt enable read zero, every table word reads zero, and `irq` is low.
- R2: Control word bits. The control word at 0x00 stores only three bits: bit 4 is the error-response select, bit 8 is auto-step and bit 31 is lockdown. Every other bit reads zero. Bit 4 also drives `err_resp_sel`.
- R3: Table access and auto-step. The data window at 0x1C reads and writes the table word chosen by the index register at 0x18. After a full-word access with auto-step set, the index goes up by one, and it wraps from `NWORDS-1` to 0. With auto-step clear, the index stays where it is.
- R4: Narrow accesses do not step. A byte or halfword access to the data window leaves the index unchanged.
- R5: Index and word count. A write to the index stores the written value modulo `NWORDS`, where `NWORDS` = ceil(`NBLOCKS`/32). The read-only word at 0x10 returns `NWORDS`.
- R6: Lockdown. While control bit 31 is set, writes to the control word, the data window and the interrupt enable have no effect, and a blocked table write does not step the index. Only reset clears lockdown.
- R7: Non-secure view. A non-secure access below 0xFD0 reads zero, raises no error and has no write effect. The identification word at 0xFD0+4k reads 0x50+k for every master, for k = 0 to 11.
- R8: Narrow writes. `req_size` 0 is a byte, 1 is a halfword and 2 is a word. Write data sits in its little-endian byte lanes. Narrow writes to the control word, the index and the data window merge the written lanes into the current value. Narrow writes to every other register clear the unwritten lanes before the write takes effect.
- R9: Block size report. The word at 0x14 reads log2(`BLK_BYTES`) - 5.
- R10: Interrupts. Status reads at 0x20. Writing bit 0 set to 0x24 clears the status. Writing bit 0 set to 0x34 sets the status, and so does a `viol_pulse`. Bit 0 of 0x28 is the enable. `irq` equals status AND enable.
- R11: Violation information. The read-only words at 0x2C and 0x30 return `viol_info1` and `viol_info2`.
- R12: Decode errors. A secure read of a write-only or unmapped offset, and a secure write to a read-only or unmapped offset, return zero data and pulse `rsp_err` for one cycle. Such a write changes no state.
- R13: Lookup port. `lk_ns` returns the table bit for block `lk_blk`, which is bit `lk_blk` mod 32 of word `lk_blk`/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_secure | input | 1 | Secure attribute of the access |
| req_addr | input | 12 | Byte address within the bank |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data in byte lanes |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Decode error, one cycle after the request |
| irq | output | 1 | Interrupt request |
| err_resp_sel | output | 1 | Error-response select for the filter |
| viol_pulse | input | 1 | Violation event from the capture logic |
| viol_info1 | input | 32 | First violation information word |
| viol_info2 | input | 32 | Second violation information word |
| lk_blk | input | clog2(NBLOCKS) | Block number to look up |
| lk_ns | output | 1 | Non-secure bit of that block |

## Verification
A request is taken on one rising edge. Its read data and error flag are registered on that same edge, so they are valid during the cycle that follows. Register state, `irq` and `lk_ns` also reflect a write from that edge onwards.

The bench drives each request on a falling edge and holds it across exactly one rising edge. It samples the response and every output on the next falling edge, which lies one register stage after the request. The index and the table contents are checked by reading them back through the bus and comparing against a model held in the bench.

// File: rtl/sec_lut_regs.sv
module sec_lut_regs #(
  parameter int NBLOCKS   = 200,
  parameter int BLK_BYTES = 4096
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_secure,
  input  logic [11:0]                req_addr,
  input  logic [1:0]                 req_size,
  input  logic [31:0]                req_wdata,
  output logic [31:0]                rsp_rdata,
  output logic                       rsp_err,
  output logic                       irq,
  output logic                       err_resp_sel,
  input  logic                       viol_pulse,
  input  logic [31:0]                viol_info1,
  input  logic [31:0]                viol_info2,
  input  logic [$clog2(NBLOCKS)-1:0] lk_blk,
  output logic                       lk_ns
);
  localparam int NWORDS = (NBLOCKS + 31) / 32;
  localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int BW     = $clog2(NBLOCKS);
  localparam int CFGV   = $clog2(BLK_BYTES) - 5;
  localparam logic [31:0] CTRL_KEEP = 32'h8000_0110;
  localparam logic [11:0] A_CTRL = 12'h000, A_CNT = 12'h010, A_CFG = 12'h014,
                          A_IDX = 12'h018, A_WIN = 12'h01C, A_STAT = 12'h020,
                          A_CLR = 12'h024, A_EN = 12'h028, A_INF1 = 12'h02C,
                          A_INF2 = 12'h030, A_SET = 12'h034, A_ID = 12'hFD0;

  logic [31:0]   ctrl;
  logic [IW-1:0] idx;
  logic          stat, en;
  logic [31:0]   tbl [NWORDS];

  logic [11:0] off;
  logic [3:0]  be;
  logic [31:0] bm, zx, rval;
  logic        rok, wok, hide, full, locked, step;
  logic [IW-1:0] idx_nx;
  logic [BW-1:0] wsel;

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [31:0] m);
    return (o & ~m) | (n & m);
  endfunction

  assign off    = {req_addr[11:2], 2'b00};
  assign be     = (req_size == 2'd0) ? (4'b0001 << req_addr[1:0]) :
                  (req_size == 2'd1) ? (4'b0011 << {req_addr[1], 1'b0}) : 4'hF;
  assign bm     = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  assign zx     = req_wdata & bm;
  assign hide   = !req_secure && (off < A_ID);
  assign full   = (req_size == 2'd2);
  assign locked = ctrl[31];
  assign step   = full && ctrl[8];
  assign idx_nx = (idx == IW'(NWORDS - 1)) ? '0 : idx + 1'b1;

  assign irq          = stat & en;
  assign err_resp_sel = ctrl[4];
  assign wsel         = lk_blk >> 5;
  assign lk_ns        = tbl[wsel[IW-1:0]][lk_blk[4:0]];

  always_comb begin
    rval = '0;
    rok  = 1'b0;
    wok  = 1'b0;
    case (off)
      A_CTRL: begin rval = ctrl; rok = 1'b1; wok = 1'b1; end
      A_CNT:  begin rval = 32'(NWORDS); rok = 1'b1; end
      A_CFG:  begin rval = 32'(CFGV); rok = 1'b1; end
      A_IDX:  begin rval = 32'(idx); rok = 1'b1; wok = 1'b1; end
      A_WIN:  begin rval = tbl[idx]; rok = 1'b1; wok = 1'b1; end
      A_STAT: begin rval = {31'd0, stat}; rok = 1'b1; end
      A_CLR:  wok = 1'b1;
      A_EN:   begin rval = {31'd0, en}; rok = 1'b1; wok = 1'b1; end
      A_INF1: begin rval = viol_info1; rok = 1'b1; end
      A_INF2: begin rval = viol_info2; rok = 1'b1; end
      A_SET:  wok = 1'b1;
      default:
        if (off >= A_ID) begin
          rval = 32'h50 + 32'((off - A_ID) >> 2);
          rok  = 1'b1;
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= 32'h0000_0100;
      idx       <= '0;
      stat      <= 1'b0;
      en        <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      for (int i = 0; i < NWORDS; i++) tbl[i] <= '0;
    end else begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      if (req_valid && !hide && !req_write) begin
        rsp_rdata <= rok ? rval : '0;
        rsp_err   <= !rok;
        if (off == A_WIN && step) idx <= idx_nx;
      end else if (req_valid && !hide && req_write) begin
        if (!wok) rsp_err <= 1'b1;
        else case (off)
          A_CTRL: if (!locked) ctrl <= mrg(ctrl, req_wdata, bm) & CTRL_KEEP;
          A_IDX:  idx <= IW'(mrg(32'(idx), req_wdata, bm) % NWORDS);
          A_WIN:  if (!locked) begin
                    tbl[idx] <= mrg(tbl[idx], req_wdata, bm);
                    if (step) idx <= idx_nx;
                  end
          A_CLR:  if (zx[0]) stat <= 1'b0;
          A_EN:   if (!locked) en <= zx[0];
          A_SET:  if (zx[0]) stat <= 1'b1;
          default: ;
        endcase
      end
      if (viol_pulse) stat <= 1'b1;
    end
  end
endmodule

module sec_lut_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_secure,
  input logic [11:0] req_addr,
  input logic [1:0]  req_size,
  input logic [31:0] req_wdata,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        irq,
  input logic        viol_pulse,
  input logic [31:0] ctrl,
  input logic        en
);
  // R7
  ns_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !req_secure && req_addr < 12'hFD0
    |=> rsp_rdata == 32'd0 && !rsp_err);
  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[31] |=> ctrl[31]);
  // R6
  lock_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[31] |=> $stable(en));
  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_secure && req_addr == 12'h024 &&
    req_size == 2'd2 && req_wdata[0] && !viol_pulse |=> !irq);
  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_secure && req_addr[11:2] == 10'd0
    |=> (rsp_rdata & ~32'h8000_0110) == 32'd0);
  // R12
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'd0);
endmodule

bind sec_lut_regs sec_lut_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
  .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .irq(irq), .viol_pulse(viol_pulse), .ctrl(ctrl), .en(en)
);

// File: tb/tb_sec_lut_regs.sv
module tb_sec_lut_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NBLOCKS = 200;
  localparam int BLK_BYTES = 4096;
  localparam int NWORDS = (NBLOCKS + 31) / 32;
  localparam int BW = $clog2(NBLOCKS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [11:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rsp_rdata;
  logic rsp_err, irq, err_resp_sel, lk_ns;
  logic viol_pulse = 0;
  logic [31:0] viol_info1 = 0, viol_info2 = 0;
  logic [BW-1:0] lk_blk = 0;

  int nchk = 0, nfail = 0;
  logic [31:0] rd;
  logic er;
  logic [31:0] model [NWORDS];
  bit done = 0;

  sec_lut_regs #(.NBLOCKS(NBLOCKS), .BLK_BYTES(BLK_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq(irq), .err_resp_sel(err_resp_sel), .viol_pulse(viol_pulse),
    .viol_info1(viol_info1), .viol_info2(viol_info2),
    .lk_blk(lk_blk), .lk_ns(lk_ns));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic s, input logic [11:0] a,
                     input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_secure = s;
    req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * 32'(i + 1);
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    do_reset();
    // R1 reset state
    acc(0, 1, 12'h000, 2, 0); chk("R1 ctrl", rd, 32'h100);
    acc(0, 1, 12'h018, 2, 0); chk("R1 idx", rd, 0);
    acc(0, 1, 12'h020, 2, 0); chk("R1 stat", rd, 0);
    acc(0, 1, 12'h028, 2, 0); chk("R1 en", rd, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    for (int i = 0; i < NWORDS; i++) begin
      acc(0, 1, 12'h01C, 2, 0); chk("R1 table", rd, 0);
    end
    // R5 count, R9 block size
    acc(0, 1, 12'h010, 2, 0); chk("R5 count", rd, NWORDS);
    acc(0, 1, 12'h014, 2, 0); chk("R9 cfg", rd, 32'($clog2(BLK_BYTES) - 5));
    // R3 streaming write, wrap and readback
    acc(1, 1, 12'h018, 2, 0);
    for (int i = 0; i < NWORDS; i++) begin
      acc(1, 1, 12'h01C, 2, pat(i)); model[i] = pat(i);
    end
    acc(0, 1, 12'h018, 2, 0); chk("R3 wrap after writes", rd, 0);
    for (int i = 0; i <= NWORDS; i++) begin
      acc(0, 1, 12'h01C, 2, 0); chk("R3 readback", rd, model[i % NWORDS]);
    end
    // R4 / R8 narrow table write merges and does not step
    acc(1, 1, 12'h018, 2, 2);
    acc(1, 1, 12'h01D, 0, 32'h0000_AB00);
    model[2] = (model[2] & ~32'h0000_FF00) | 32'h0000_AB00;
    acc(0, 1, 12'h018, 2, 0); chk("R4 idx after byte write", rd, 2);
    acc(0, 1, 12'h01E, 1, 0);
    acc(0, 1, 12'h018, 2, 0); chk("R4 idx after half read", rd, 2);
    acc(0, 1, 12'h01C, 2, 0); chk("R8 table merge", rd, model[2]);
    acc(0, 1, 12'h018, 2, 0); chk("R3 step to 3", rd, 3);
    // R5 index modulo sweep
    for (int v = 0; v < 3 * NWORDS; v++) begin
      acc(1, 1, 12'h018, 2, 32'(v));
      acc(0, 1, 12'h018, 2, 0); chk("R5 idx modulo", rd, 32'(v % NWORDS));
    end
    // R8 narrow merges into idx
    acc(1, 1, 12'h018, 2, 5);
    acc(1, 1, 12'h019, 0, 32'h0000_0100);
    acc(0, 1, 12'h018, 2, 0); chk("R8 idx merge", rd, 32'(261 % NWORDS));
    // R8 ctrl merge and zero-extend on enable
    acc(1, 1, 12'h000, 0, 32'h0000_0010);
    acc(0, 1, 12'h000, 2, 0); chk("R8 ctrl merge", rd, 32'h110);
    chk("R2 err_resp_sel", {31'd0, err_resp_sel}, 1);
    acc(1, 1, 12'h028, 2, 1);
    acc(1, 1, 12'h029, 0, 32'hFFFF_FFFF);
    acc(0, 1, 12'h028, 2, 0); chk("R8 enable zero-extend", rd, 0);
    // R2 reserved bits
    acc(1, 1, 12'h000, 2, 32'h7FFF_FFFF);
    acc(0, 1, 12'h000, 2, 0); chk("R2 ctrl keep", rd, 32'h110);
    acc(1, 1, 12'h000, 2, 0);
    acc(0, 1, 12'h000, 2, 0); chk("R2 ctrl zero", rd, 0);
    // R3 no step with auto-step off
    acc(1, 1, 12'h018, 2, 4);
    acc(0, 1, 12'h01C, 2, 0); chk("R3 no-step read", rd, model[4]);
    acc(0, 1, 12'h01C, 2, 0); chk("R3 no-step read again", rd, model[4]);
    acc(0, 1, 12'h018, 2, 0); chk("R3 idx held", rd, 4);
    acc(1, 1, 12'h000, 2, 32'h100);
    // R10 interrupts
    acc(1, 1, 12'h028, 2, 1);
    acc(1, 1, 12'h034, 2, 1);
    chk("R10 irq set", {31'd0, irq}, 1);
    acc(0, 1, 12'h020, 2, 0); chk("R10 stat set", rd, 1);
    acc(1, 1, 12'h024, 2, 1);
    chk("R10 irq clear", {31'd0, irq}, 0);
    acc(1, 1, 12'h028, 2, 0);
    @(negedge clk); viol_pulse = 1;
    @(negedge clk); viol_pulse = 0;
    acc(0, 1, 12'h020, 2, 0); chk("R10 viol sets stat", rd, 1);
    chk("R10 irq masked", {31'd0, irq}, 0);
    acc(1, 1, 12'h024, 2, 1);
    // R11 info words
    viol_info1 = 32'hCAFE_0123; viol_info2 = 32'h0003_4567;
    acc(0, 1, 12'h02C, 2, 0); chk("R11 info1", rd, 32'hCAFE_0123);
    acc(0, 1, 12'h030, 2, 0); chk("R11 info2", rd, 32'h0003_4567);
    // R12 decode errors
    acc(0, 1, 12'h024, 2, 0); chk("R12 read wo data", rd, 0); chk("R12 read wo err", {31'd0, er}, 1);
    acc(0, 1, 12'h800, 2, 0); chk("R12 unmapped err", {31'd0, er}, 1);
    acc(1, 1, 12'h020, 2, 1); chk("R12 write ro err", {31'd0, er}, 1);
    acc(0, 1, 12'h020, 2, 0); chk("R12 stat untouched", rd, 0);
    acc(0, 1, 12'h000, 2, 0); chk("R12 good read no err", {31'd0, er}, 0);
    // R7 non-secure view
    acc(0, 0, 12'h000, 2, 0); chk("R7 ns read zero", rd, 0); chk("R7 ns no err", {31'd0, er}, 0);
    acc(1, 0, 12'h000, 2, 0);
    acc(0, 1, 12'h000, 2, 0); chk("R7 ns write dropped", rd, 32'h100);
    acc(1, 1, 12'h018, 2, 1);
    acc(1, 0, 12'h01C, 2, 32'h1234_5678);
    acc(0, 1, 12'h018, 2, 0); chk("R7 ns idx unchanged", rd, 1);
    acc(0, 1, 12'h01C, 2, 0); chk("R7 ns table unchanged", rd, model[1]);
    for (int k = 0; k < 12; k++) begin
      acc(0, 0, 12'(12'hFD0 + 4 * k), 2, 0); chk("R7 id word", rd, 32'(8'h50 + k));
    end
    // R13 lookup sweep
    for (int b = 0; b < NBLOCKS; b++) begin
      lk_blk = BW'(b); #1;
      chk("R13 lookup", {31'd0, lk_ns}, {31'd0, model[b / 32][b % 32]});
    end
    // R6 lockdown
    acc(1, 1, 12'h000, 2, 32'h8000_0100);
    acc(1, 1, 12'h000, 2, 0);
    acc(0, 1, 12'h000, 2, 0); chk("R6 ctrl frozen", rd, 32'h8000_0100);
    acc(1, 1, 12'h018, 2, 0);
    acc(1, 1, 12'h01C, 2, 32'hFFFF_FFFF);
    acc(0, 1, 12'h018, 2, 0); chk("R6 no step on blocked write", rd, 0);
    acc(0, 1, 12'h01C, 2, 0); chk("R6 table frozen", rd, model[0]);
    acc(1, 1, 12'h028, 2, 1);
    acc(0, 1, 12'h028, 2, 0); chk("R6 enable frozen", rd, 0);
    do_reset();
    acc(0, 1, 12'h000, 2, 0); chk("R6 reset clears lock", rd, 32'h100);
    acc(0, 1, 12'h01C, 2, 0); chk("R1 table cleared by reset", rd, 0);
    finish_up();
  end
endmodule